// File: doc/BRIEF.md
# Immediate-Operand Instruction Executor

This block takes in a byte stream holding a small set of 32-bit instructions that each carry a 32-bit immediate, and it executes them one at a time. It holds eight 32-bit general registers and three condition flags (sign, zero, overflow). It reaches data memory through a simple synchronous word port: a read returns data in the cycle after the request, and a write takes effect at the clock edge where it is driven.

Five operations are supported: bitwise OR, bitwise XOR, compare, copy and push. One shared execute path serves every opcode form. Opcode 0x81 is a group opcode, and the reg field of its ModRM byte picks OR, XOR or compare. Two short forms, 0x35 and 0x3D, work on register 0 without a ModRM byte. When an instruction finishes, the block pulses a done output. Any byte it cannot handle stops the block until the next reset.

Top module: `immop_exec`

## Requirements
- R1: During and after a synchronous active-low reset, all registers and flags are zero, `insn_done`, `err_illegal` and `err_align` are low, and `byte_ready` is high.
- R2: The immediate is the four stream bytes that follow the opcode, or follow the ModRM byte when there is one. The first of these bytes is bits 7:0 and the last is bits 31:24.
- R3: Opcode 0x81 with ModRM reg field 1 ORs the immediate into the operand, and with reg field 6 XORs it in. The result is written back. OR and XOR leave the flags unchanged.
- R4: Compare (0x81 with reg field 7, or 0x3D on register 0) computes operand minus immediate. Sign is set when bit 31 of the difference is 1. Zero is set when the difference is zero. Overflow is set when the signed difference does not fit in 32 bits. Nothing is written back.
- R5: Opcode 0x35 XORs the immediate into register 0.
- R6: ModRM bits 7:6 = 11 select register bits 2:0 as the operand. Bits 7:6 = 00 select the memory word at the address held in that register. For a memory OR or XOR, the block reads that word and writes the result back to the same address.
- R7: Opcode 0xB8 with a ModRM byte copies the immediate into the register named by ModRM bits 2:0. Bits 7:6 of that ModRM byte are ignored.
- R8: Opcode 0xC7 with a ModRM byte stores the immediate into the operand chosen as in R6.
- R9: Opcode 0x68 lowers register 4 by 4 and stores the immediate at the lowered address. Both updates happen in the same cycle.
- R10: If a memory address has either of its low two bits set, the block raises `err_align`, makes no memory access, and stops.
- R11: The block raises `err_illegal`, drops `byte_ready` and stops until reset when it meets any of these: an opcode outside {0x81, 0x35, 0x3D, 0xB8, 0xC7, 0x68}; opcode 0x81 with a reg field other than 1, 6 or 7; opcode 0x81 or 0xC7 with ModRM bits 7:6 equal to 01 or 10.
- R12: `insn_done` is high for exactly one cycle when an instruction completes. In that same cycle the block accepts the next opcode byte, which is the byte right after the last immediate byte.
- R13: `byte_ready` stays low while an instruction executes, so stream bytes offered in that time are not consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| byte_valid | input | 1 | A stream byte is offered |
| byte_data | input | 8 | Offered stream byte |
| byte_ready | output | 1 | The block consumes the offered byte at this edge |
| dmem_addr | output | 32 | Byte address of the data word |
| dmem_rd | output | 1 | Read request; data is returned in the next cycle |
| dmem_wr | output | 1 | Write strobe |
| dmem_wdata | output | 32 | Write data |
| dmem_rdata | input | 32 | Read data, valid in the cycle after `dmem_rd` |
| insn_done | output | 1 | One-cycle pulse at the end of an instruction |
| flag_sign | output | 1 | Sign flag |
| flag_zero | output | 1 | Zero flag |
| flag_ovf | output | 1 | Overflow flag |
| err_illegal | output | 1 | Unsupported encoding seen; the block has stopped |
| err_align | output | 1 | Misaligned memory address seen; the block has stopped |

## Verification
Two things can fall into the same cycle. The first is the done pulse of one instruction together with the fetch of the next opcode. The bench streams two instructions back to back with `byte_valid` held high. It checks that a cycle occurs in which `insn_done`, `byte_valid` and `byte_ready` are all high, that exactly two done pulses appear, and that the second instruction then sees the result the first one left. The second coincidence is a push, whose register-4 update and memory store share one edge. The bench checks the stored word and, through a compare, the new register 4 value after a single done pulse.

// File: rtl/immop_pkg.sv
// Shared types for the immediate-operand executor.
// Assumes an 8-bit stream and 3-bit ModRM register fields.
package immop_pkg;

    // Opcode byte values that the executor recognises.
    localparam logic [7:0] OPC_GROUP   = 8'h81;
    localparam logic [7:0] OPC_XOR_ACC = 8'h35;
    localparam logic [7:0] OPC_CMP_ACC = 8'h3D;
    localparam logic [7:0] OPC_COPY_R  = 8'hB8;
    localparam logic [7:0] OPC_STORE   = 8'hC7;
    localparam logic [7:0] OPC_PUSH    = 8'h68;

    // Operations performed by the shared execute path.
    typedef enum logic [1:0] {
        ALU_OR,
        ALU_XOR,
        ALU_CMP,
        ALU_PASS
    } alu_op_t;

    // Instruction class after the opcode is decoded.
    typedef enum logic [2:0] {
        K_GRP,
        K_XACC,
        K_CACC,
        K_MOVR,
        K_MOVM,
        K_PUSH,
        K_BAD
    } op_kind_t;

    // Sequencer states.
    typedef enum logic [2:0] {
        ST_OPC,
        ST_MODRM,
        ST_IMM,
        ST_EXEC,
        ST_MEMRD,
        ST_HALT
    } ex_state_t;

endpackage

// File: rtl/iu_decode.sv
// Opcode and ModRM classifier. Purely combinational.
// Assumes modrm is meaningful only for kinds that carry a ModRM byte.
module iu_decode
    import immop_pkg::*;
(
    input  logic [7:0] opc,
    input  logic [7:0] modrm,
    output op_kind_t   kind,
    output logic       has_modrm,
    output logic       modrm_ok,
    output alu_op_t    aop
);

    logic [1:0] mod_f;
    logic [2:0] reg_f;

    assign mod_f = modrm[7:6];
    assign reg_f = modrm[5:3];

    // Map the opcode byte to an instruction class.
    always_comb begin
        case (opc)
            OPC_GROUP:   kind = K_GRP;
            OPC_XOR_ACC: kind = K_XACC;
            OPC_CMP_ACC: kind = K_CACC;
            OPC_COPY_R:  kind = K_MOVR;
            OPC_STORE:   kind = K_MOVM;
            OPC_PUSH:    kind = K_PUSH;
            default:     kind = K_BAD;
        endcase
    end

    assign has_modrm = (kind == K_GRP) || (kind == K_MOVR) || (kind == K_MOVM);

    // Judge whether the ModRM byte is supported for this class.
    always_comb begin
        case (kind)
            K_GRP:   modrm_ok = (reg_f == 3'd1 || reg_f == 3'd6 || reg_f == 3'd7) &&
                                (mod_f == 2'b00 || mod_f == 2'b11);
            K_MOVM:  modrm_ok = (mod_f == 2'b00 || mod_f == 2'b11);
            default: modrm_ok = 1'b1;
        endcase
    end

    // Choose the operation for the execute path.
    always_comb begin
        case (kind)
            K_GRP: begin
                case (reg_f)
                    3'd1:    aop = ALU_OR;
                    3'd6:    aop = ALU_XOR;
                    3'd7:    aop = ALU_CMP;
                    default: aop = ALU_PASS;
                endcase
            end
            K_XACC:  aop = ALU_XOR;
            K_CACC:  aop = ALU_CMP;
            default: aop = ALU_PASS;
        endcase
    end

endmodule

// File: rtl/iu_alu.sv
// Execute datapath shared by every opcode form: OR, XOR, subtract-compare, pass.
// Assumes two's-complement operands; wr_back is low only for compare.
module iu_alu
    import immop_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  alu_op_t         op,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] res,
    output logic            wr_back,
    output logic            f_sign,
    output logic            f_zero,
    output logic            f_ovf
);

    localparam int MSB = XLEN - 1;

    logic [XLEN-1:0] diff;

    assign diff = a - b;

    // Pick the result word for the selected operation.
    always_comb begin
        case (op)
            ALU_OR:  res = a | b;
            ALU_XOR: res = a ^ b;
            ALU_CMP: res = diff;
            default: res = b;
        endcase
    end

    assign wr_back = (op != ALU_CMP);
    assign f_sign  = diff[MSB];
    assign f_zero  = (diff == '0);
    assign f_ovf   = (a[MSB] != b[MSB]) && (diff[MSB] != a[MSB]);

endmodule

// File: rtl/iu_regfile.sv
// General register file: one combinational read port, one synchronous write port.
// Assumes synchronous active-low reset clears every entry.
module iu_regfile #(
    parameter int XLEN = 32,
    parameter int NREG = 8,
    localparam int RW  = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [RW-1:0]   ra,
    output logic [XLEN-1:0] rd,
    input  logic            we,
    input  logic [RW-1:0]   wa,
    input  logic [XLEN-1:0] wd
);

    logic [XLEN-1:0] regs [NREG];

    // Clear on reset, otherwise write the addressed entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (we) begin
            regs[wa] <= wd;
        end
    end

    assign rd = regs[ra];

endmodule

// File: rtl/immop_exec.sv
// Immediate-operand instruction executor: fetches opcode, optional ModRM and a
// little-endian immediate from a byte stream, then performs OR/XOR/compare/copy/push
// on a register or a memory word. Assumes memory reads return one cycle after request.
module immop_exec
    import immop_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int NREG    = 8,
    parameter int SP_IDX  = 4,
    parameter int ACC_IDX = 0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            byte_valid,
    input  logic [7:0]      byte_data,
    output logic            byte_ready,
    output logic [XLEN-1:0] dmem_addr,
    output logic            dmem_rd,
    output logic            dmem_wr,
    output logic [XLEN-1:0] dmem_wdata,
    input  logic [XLEN-1:0] dmem_rdata,
    output logic            insn_done,
    output logic            flag_sign,
    output logic            flag_zero,
    output logic            flag_ovf,
    output logic            err_illegal,
    output logic            err_align
);

    localparam int IMM_BYTES = XLEN / 8;
    localparam int CW        = (IMM_BYTES > 1) ? $clog2(IMM_BYTES) : 1;
    localparam int AL        = CW;
    localparam int RW        = $clog2(NREG);
    localparam logic [XLEN-1:0] WORD_STEP = XLEN'(IMM_BYTES);
    localparam logic [CW-1:0]   LAST_IMM  = CW'(IMM_BYTES - 1);

    ex_state_t       state;
    logic [7:0]      opc_q, modrm_q;
    logic [XLEN-1:0] imm_q;
    logic [CW-1:0]   cnt_q;
    logic            done_q, ill_q, mis_q;
    logic            sf_q, zf_q, of_q;

    logic [7:0]      dec_opc, dec_modrm;
    op_kind_t        kind;
    logic            has_modrm, modrm_ok;
    alu_op_t         aop;

    logic [RW-1:0]   tgt;
    logic [XLEN-1:0] rd_val, sp_next, eff_addr, alu_a, alu_res;
    logic            is_mem, touches_mem, misal;
    logic            alu_wr, a_sf, a_zf, a_of;
    logic            rf_we, flag_upd;
    logic [XLEN-1:0] rf_wd;

    // Decode sees the live byte while it is being fetched, the latched one afterwards.
    assign dec_opc   = (state == ST_OPC)   ? byte_data : opc_q;
    assign dec_modrm = (state == ST_MODRM) ? byte_data : modrm_q;

    iu_decode u_decode (
        .opc       (dec_opc),
        .modrm     (dec_modrm),
        .kind      (kind),
        .has_modrm (has_modrm),
        .modrm_ok  (modrm_ok),
        .aop       (aop)
    );

    // Select the register that is the operand, the address base or the stack pointer.
    always_comb begin
        case (kind)
            K_XACC, K_CACC: tgt = RW'(ACC_IDX);
            K_PUSH:         tgt = RW'(SP_IDX);
            default:        tgt = modrm_q[RW-1:0];
        endcase
    end

    iu_regfile #(.XLEN(XLEN), .NREG(NREG)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .ra    (tgt),
        .rd    (rd_val),
        .we    (rf_we),
        .wa    (tgt),
        .wd    (rf_wd)
    );

    assign is_mem      = (kind == K_GRP || kind == K_MOVM) && (modrm_q[7:6] == 2'b00);
    assign touches_mem = is_mem || (kind == K_PUSH);
    assign sp_next     = rd_val - WORD_STEP;
    assign eff_addr    = (kind == K_PUSH) ? sp_next : rd_val;
    assign misal       = touches_mem && (eff_addr[AL-1:0] != '0);
    assign alu_a       = (state == ST_MEMRD) ? dmem_rdata : rd_val;

    iu_alu #(.XLEN(XLEN)) u_alu (
        .op      (aop),
        .a       (alu_a),
        .b       (imm_q),
        .res     (alu_res),
        .wr_back (alu_wr),
        .f_sign  (a_sf),
        .f_zero  (a_zf),
        .f_ovf   (a_of)
    );

    // Drive memory, register write and flag-update strobes for the current step.
    always_comb begin
        dmem_rd  = 1'b0;
        dmem_wr  = 1'b0;
        rf_we    = 1'b0;
        flag_upd = 1'b0;
        if (state == ST_EXEC && !misal) begin
            dmem_rd  = (kind == K_GRP) && is_mem;
            dmem_wr  = (kind == K_PUSH) || (kind == K_MOVM && is_mem);
            rf_we    = (kind == K_PUSH) || (!touches_mem && alu_wr);
            flag_upd = !is_mem && (aop == ALU_CMP);
        end else if (state == ST_MEMRD) begin
            dmem_wr  = alu_wr;
            flag_upd = (aop == ALU_CMP);
        end
    end

    assign rf_wd      = (kind == K_PUSH) ? sp_next : alu_res;
    assign dmem_addr  = eff_addr;
    assign dmem_wdata = alu_res;
    assign byte_ready = (state == ST_OPC) || (state == ST_MODRM) || (state == ST_IMM);

    // Sequencer: fetch, assemble immediate, execute, flag and error bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_OPC;
            opc_q   <= '0;
            modrm_q <= '0;
            imm_q   <= '0;
            cnt_q   <= '0;
            done_q  <= 1'b0;
            ill_q   <= 1'b0;
            mis_q   <= 1'b0;
            sf_q    <= 1'b0;
            zf_q    <= 1'b0;
            of_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (flag_upd) begin
                sf_q <= a_sf;
                zf_q <= a_zf;
                of_q <= a_of;
            end
            case (state)
                ST_OPC: if (byte_valid) begin
                    opc_q <= byte_data;
                    cnt_q <= '0;
                    if (kind == K_BAD) begin
                        ill_q <= 1'b1;
                        state <= ST_HALT;
                    end else if (has_modrm) begin
                        state <= ST_MODRM;
                    end else begin
                        state <= ST_IMM;
                    end
                end
                ST_MODRM: if (byte_valid) begin
                    modrm_q <= byte_data;
                    if (!modrm_ok) begin
                        ill_q <= 1'b1;
                        state <= ST_HALT;
                    end else begin
                        state <= ST_IMM;
                    end
                end
                ST_IMM: if (byte_valid) begin
                    imm_q <= {byte_data, imm_q[XLEN-1:8]};
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == LAST_IMM) state <= ST_EXEC;
                end
                ST_EXEC: begin
                    if (misal) begin
                        mis_q <= 1'b1;
                        state <= ST_HALT;
                    end else if (dmem_rd) begin
                        state <= ST_MEMRD;
                    end else begin
                        done_q <= 1'b1;
                        state  <= ST_OPC;
                    end
                end
                ST_MEMRD: begin
                    done_q <= 1'b1;
                    state  <= ST_OPC;
                end
                default: state <= ST_HALT;
            endcase
        end
    end

    assign insn_done   = done_q;
    assign err_illegal = ill_q;
    assign err_align   = mis_q;
    assign flag_sign   = sf_q;
    assign flag_zero   = zf_q;
    assign flag_ovf    = of_q;

    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        insn_done |=> !insn_done);

    // R10
    align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dmem_rd || dmem_wr) |-> (dmem_addr[AL-1:0] == '0));

    // R6
    rmw_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_rd |=> (dmem_wr || !alu_wr) && dmem_addr == $past(dmem_addr));

    // R13
    busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_rd |=> !byte_ready);

    // R11
    halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_illegal |=> err_illegal && !byte_ready && !insn_done);

    // R4
    flag_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({flag_sign, flag_zero, flag_ovf}) |-> $past(flag_upd));

endmodule

// File: tb/immop_exec_tb.sv
`timescale 1ns/1ps
module immop_exec_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        byte_valid = 1'b0;
    logic [7:0]  byte_data = 8'h00;
    logic        byte_ready;
    logic [31:0] dmem_addr, dmem_wdata;
    logic [31:0] dmem_rdata = 32'h0;
    logic        dmem_rd, dmem_wr;
    logic        insn_done, flag_sign, flag_zero, flag_ovf, err_illegal, err_align;

    int vec = 0;
    int mis = 0;
    int done_cnt = 0;
    int rd_cnt = 0;
    int wr_cnt = 0;
    bit overlap_seen = 1'b0;
    bit finished = 1'b0;
    logic [31:0] mem [64];

    always #4 clk = ~clk;

    immop_exec u_dut (
        .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_data(byte_data),
        .byte_ready(byte_ready), .dmem_addr(dmem_addr), .dmem_rd(dmem_rd), .dmem_wr(dmem_wr),
        .dmem_wdata(dmem_wdata), .dmem_rdata(dmem_rdata), .insn_done(insn_done),
        .flag_sign(flag_sign), .flag_zero(flag_zero), .flag_ovf(flag_ovf),
        .err_illegal(err_illegal), .err_align(err_align)
    );

    // Word memory model with one-cycle read latency.
    always @(posedge clk) begin
        if (dmem_wr) begin
            mem[dmem_addr[7:2]] <= dmem_wdata;
            wr_cnt <= wr_cnt + 1;
        end
        if (dmem_rd) begin
            dmem_rdata <= mem[dmem_addr[7:2]];
            rd_cnt <= rd_cnt + 1;
        end
    end

    // Count done pulses and note a done coinciding with a byte handoff.
    always @(negedge clk) begin
        if (insn_done) done_cnt <= done_cnt + 1;
        if (insn_done && byte_valid && byte_ready) overlap_seen <= 1'b1;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vec++;
        if (act !== exp) begin
            mis++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        byte_valid = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b);
        byte_data = b;
        byte_valid = 1'b1;
        while (!byte_ready) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic send_ins(input logic [7:0] op, input bit hm, input logic [7:0] m,
                            input logic [31:0] imm);
        send_byte(op);
        if (hm) send_byte(m);
        for (int i = 0; i < 4; i++) send_byte(imm[8*i +: 8]);
    endtask

    task automatic wait_done(input string tag);
        int n = 0;
        while (!insn_done && n < 20) begin
            @(negedge clk);
            n++;
        end
        check({tag, " done pulse"}, 32'(insn_done), 32'd1);
        @(negedge clk);
    endtask

    task automatic run_ins(input string tag, input logic [7:0] op, input bit hm,
                           input logic [7:0] m, input logic [31:0] imm);
        send_ins(op, hm, m, imm);
        byte_valid = 1'b0;
        wait_done(tag);
    endtask

    // Load a register through the copy form (ModRM bits 7:6 = 11).
    task automatic load(input int idx, input logic [31:0] v);
        run_ins("load", 8'hB8, 1'b1, 8'hC0 | 8'(idx), v);
    endtask

    // Observe a register through a compare; equal values set the zero flag.
    task automatic expect_reg(input string tag, input int idx, input logic [31:0] v);
        run_ins(tag, 8'h81, 1'b1, 8'hF8 | 8'(idx), v);
        check(tag, 32'(flag_zero), 32'd1);
    endtask

    task automatic t_reset();
        check("R1 ready", 32'(byte_ready), 32'd1);
        check("R1 done", 32'(insn_done), 32'd0);
        check("R1 flags", {29'd0, flag_sign, flag_zero, flag_ovf}, 32'd0);
        check("R1 errors", {30'd0, err_illegal, err_align}, 32'd0);
        expect_reg("R1 reg3 zero", 3, 32'h0);
    endtask

    task automatic t_or_reg();
        load(0, 32'h0);
        run_ins("R4 set", 8'h3D, 1'b0, 8'h00, 32'h1);
        check("R4 minus one", {29'd0, flag_sign, flag_zero, flag_ovf}, 32'b100);
        load(3, 32'hd0c0b0a0);
        run_ins("R3 or", 8'h81, 1'b1, 8'hCB, 32'h0d0c0b0a);
        check("R3 or keeps flags", {29'd0, flag_sign, flag_zero, flag_ovf}, 32'b100);
        expect_reg("R3 or result", 3, 32'hddccbbaa);
    endtask

    task automatic t_xor_mem();
        int r0, w0;
        load(3, 32'h60);
        mem[24] = 32'hd0c0b0a0;
        r0 = rd_cnt;
        w0 = wr_cnt;
        run_ins("R6 xor mem", 8'h81, 1'b1, 8'h33, 32'h0d0c0b0a);
        check("R6 xor mem word", mem[24], 32'hddccbbaa);
        check("R6 one read", 32'(rd_cnt - r0), 32'd1);
        check("R3 one write", 32'(wr_cnt - w0), 32'd1);
        expect_reg("R6 base kept", 3, 32'h60);
    endtask

    task automatic t_xor_acc();
        load(0, 32'hddccb0a0);
        run_ins("R5 xor acc", 8'h35, 1'b0, 8'h00, 32'h0d0c0b0a);
        expect_reg("R5 acc result", 0, 32'hd0c0bbaa);
    endtask

    task automatic t_compare();
        int w0;
        load(0, 32'h0d0c0b0a);
        run_ins("R4 acc gt", 8'h3D, 1'b0, 8'h00, 32'h0d0c0b07);
        check("R4 acc gt flags", {29'd0, flag_sign, flag_zero, flag_ovf}, 32'b000);
        load(0, 32'h0d0c0b07);
        run_ins("R4 acc lt", 8'h3D, 1'b0, 8'h00, 32'h0d0c0b0a);
        check("R4 acc lt flags", {29'd0, flag_sign, flag_zero, flag_ovf}, 32'b100);
        load(0, 32'h80000000);
        run_ins("R4 ovf", 8'h3D, 1'b0, 8'h00, 32'h1);
        check("R4 ovf flags", {29'd0, flag_sign, flag_zero, flag_ovf}, 32'b001);
        load(3, 32'h0d0c0b07);
        run_ins("R4 reg lt", 8'h81, 1'b1, 8'hFB, 32'h0d0c0b0a);
        check("R4 reg lt flags", {29'd0, flag_sign, flag_zero, flag_ovf}, 32'b100);
        load(3, 32'h60);
        mem[24] = 32'h0d0c0b0a;
        w0 = wr_cnt;
        run_ins("R4 mem eq", 8'h81, 1'b1, 8'h3B, 32'h0d0c0b0a);
        check("R4 mem eq flags", {29'd0, flag_sign, flag_zero, flag_ovf}, 32'b010);
        check("R4 mem no write", 32'(wr_cnt - w0), 32'd0);
    endtask

    task automatic t_copy();
        run_ins("R7 copy mod00", 8'hB8, 1'b1, 8'h03, 32'h11223344);
        expect_reg("R2 R7 byte order", 3, 32'h11223344);
        run_ins("R7 copy mod11", 8'hB8, 1'b1, 8'hC5, 32'h0d0c0b0a);
        expect_reg("R7 reg5", 5, 32'h0d0c0b0a);
    endtask

    task automatic t_store();
        load(3, 32'h60);
        mem[24] = 32'h0;
        run_ins("R8 store mem", 8'hC7, 1'b1, 8'h03, 32'h0d0c0b0a);
        check("R8 mem word", mem[24], 32'h0d0c0b0a);
        run_ins("R8 store reg", 8'hC7, 1'b1, 8'hC3, 32'hcafe0042);
        expect_reg("R8 reg3", 3, 32'hcafe0042);
    endtask

    task automatic t_push();
        int d0;
        load(4, 32'h14);
        d0 = done_cnt;
        run_ins("R9 push", 8'h68, 1'b0, 8'h00, 32'h000000af);
        check("R9 single done", 32'(done_cnt - d0), 32'd1);
        check("R9 stored", mem[4], 32'h000000af);
        expect_reg("R9 sp", 4, 32'h10);
    endtask

    task automatic t_back_to_back();
        int d0;
        load(0, 32'h0);
        d0 = done_cnt;
        overlap_seen = 1'b0;
        send_ins(8'h35, 1'b0, 8'h00, 32'h00ff00ff);
        check("R13 busy after last byte", 32'(byte_ready), 32'd0);
        send_ins(8'h3D, 1'b0, 8'h00, 32'h00ff00ff);
        byte_valid = 1'b0;
        wait_done("R12 second");
        check("R12 two dones", 32'(done_cnt - d0), 32'd2);
        check("R12 overlap", 32'(overlap_seen), 32'd1);
        check("R12 chained result", 32'(flag_zero), 32'd1);
    endtask

    task automatic t_misalign();
        int r0, w0;
        load(3, 32'h62);
        r0 = rd_cnt;
        w0 = wr_cnt;
        send_ins(8'h81, 1'b1, 8'h0B, 32'h1);
        byte_valid = 1'b0;
        repeat (3) @(negedge clk);
        check("R10 align error", 32'(err_align), 32'd1);
        check("R10 stopped", 32'(byte_ready), 32'd0);
        check("R10 no access", 32'(rd_cnt - r0 + wr_cnt - w0), 32'd0);
        do_reset();
    endtask

    task automatic t_illegal(input logic [7:0] op, input bit hm, input logic [7:0] m,
                             input string tag);
        send_byte(op);
        if (hm) send_byte(m);
        byte_valid = 1'b0;
        repeat (2) @(negedge clk);
        check(tag, 32'(err_illegal), 32'd1);
        check({tag, " stopped"}, 32'(byte_ready), 32'd0);
        do_reset();
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            mis++;
            $display("FAIL R12 watchdog expired: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vec, mis);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 32'h0;
        do_reset();
        t_reset();
        t_or_reg();
        t_xor_mem();
        t_xor_acc();
        t_compare();
        t_copy();
        t_store();
        t_push();
        t_back_to_back();
        t_misalign();
        t_illegal(8'h90, 1'b0, 8'h00, "R11 bad opcode");
        t_illegal(8'h81, 1'b1, 8'hD3, "R11 bad group reg");
        t_illegal(8'h81, 1'b1, 8'h4B, "R11 bad mod");
        t_reset();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vec, mis);
        $finish;
    end

endmodule